// File: doc/BRIEF.md
# Retriggerable Edge-Started Interval Timer

The block is a down-counting interval timer. Software arms it by setting an enable bit. Falling edges on an external trigger pin then start the count. Each qualifying falling edge loads the counter from a programmed start value and begins counting again. A one-cycle interrupt pulse appears only once the programmed number of prescale ticks has gone by with no further falling edge. The interrupt therefore marks a quiet gap after the latest edge, not a free-running period.

The counter decrements only in cycles where an external prescale tick is high. The trigger pin is asynchronous, so it passes through a synchronizer before edge detection. A run-mode input selects between two behaviours:

- **Single-pass:** the first end of count drops the enable bit.
- **Continuous:** the counter reloads itself at each end of count and runs until software clears the enable bit.

Edges start the timer only when the 2-bit trigger-mode field holds 2'b11.

Top module: `retrig_timer`

## Requirements
- R1: After a synchronous reset, `irq_o` is 0 and `en_o` is 0.
- R2: With `mode_i` = 2'b11, `en_o` = 1 and `tick_i` held high, a falling edge on `trig_i` loads the start value. `irq_o` then pulses exactly `init_i` + 3 clock cycles after the pin falls: 2 cycles of synchronizer, 1 cycle of load, then `init_i` ticks. An `init_i` of 0 counts 2^W ticks.
- R3: The counter decrements only in cycles with `tick_i` = 1. The interrupt comes on the `init_i`-th tick after the load.
- R4: In single-pass mode (`cont_i` = 0), the end of count raises one `irq_o` pulse and clears `en_o` in the same cycle.
- R5: After a single-pass end of count, falling edges on `trig_i` cause no interrupt until `en_set_i` is pulsed again.
- R6: Falling edges have no effect while `en_o` = 0 or while `mode_i` is not 2'b11.
- R7: In continuous mode (`cont_i` = 1), the counter reloads at every end of count, so `irq_o` pulses every `init_i` ticks. A pulse on `en_clr_i` stops counting and clears `en_o`, and no further interrupt follows.
- R8: A falling edge while counting reloads the counter, so the interrupt comes `init_i` ticks after the most recent edge. Rising edges have no effect.
- R9: When a falling edge and an end of count occur in the same cycle, the interrupt is still raised and the reload wins. The timer keeps running, with `en_o` staying 1 even in single-pass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescale tick; the count advances in cycles where it is high |
| trig_i | input | 1 | Asynchronous trigger pin; falling edges start or restart the count |
| init_i | input | W | Start value loaded on each trigger |
| mode_i | input | 2 | Trigger-mode field; 2'b11 selects edge-started operation |
| cont_i | input | 1 | 1 = continuous, 0 = single-pass |
| en_set_i | input | 1 | One-cycle pulse that sets the enable bit |
| en_clr_i | input | 1 | One-cycle pulse that clears the enable bit and stops counting (wins over set) |
| en_o | output | 1 | Current enable bit |
| irq_o | output | 1 | Registered end-of-count interrupt pulse |

## Verification
The assertions assume three things about the inputs:

- `init_i`, `mode_i` and `cont_i` stay constant while the timer runs.
- `trig_i` is held at each level for at least two clock cycles, so every edge survives the synchronizer.
- `tick_i` is a plain level sampled every cycle.

The stimulus changes configuration only while the timer is idle. It drives the trigger pin with levels lasting two or more cycles, one cycle after a clock edge. Each expected interrupt cycle is computed from the start value, the three-cycle pin-to-load latency and a count of the ticks applied.

// File: rtl/retrig_pkg.sv
package retrig_pkg;
  localparam logic [1:0] TRIG_MODE_RETRIG = 2'b11;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];

  // R2: a detected falling edge lasts exactly one cycle
  a_r2_single_edge: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ivl_counter.sv
module ivl_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic [W-1:0] init_i,
  output logic         at_one_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= init_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  assign at_one_o = (cnt_q == ONE);

  // R3: the count holds when neither a load nor a tick was present
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_i) && !$past(dec_i)) |-> $stable(cnt_q));
endmodule

// File: rtl/retrig_timer.sv
module retrig_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         trig_i,
  input  logic [W-1:0] init_i,
  input  logic [1:0]   mode_i,
  input  logic         cont_i,
  input  logic         en_set_i,
  input  logic         en_clr_i,
  output logic         en_o,
  output logic         irq_o
);
  import retrig_pkg::*;

  logic fall, at_one, start, eoc, load;
  logic en_q, run_q, irq_q;

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(trig_i), .fall_o(fall)
  );

  assign start = fall & en_q & (mode_i == TRIG_MODE_RETRIG);
  assign eoc   = run_q & tick_i & at_one;
  assign load  = start | (eoc & cont_i);

  ivl_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(load), .dec_i(run_q & tick_i),
    .init_i(init_i), .at_one_o(at_one)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= eoc;
      if (en_clr_i) begin
        en_q  <= 1'b0;
        run_q <= 1'b0;
      end else begin
        if (en_set_i) en_q <= 1'b1;
        if (start) run_q <= 1'b1;
        else if (eoc && !cont_i) begin
          run_q <= 1'b0;
          en_q  <= 1'b0;
        end
      end
    end
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;

  // R6: no interrupt can follow a cycle in which the enable bit was clear
  a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !$past(en_q) |-> !irq_o);

  // R6: counting never begins while the trigger mode is not edge-started
  a_r6_no_start_wrong_mode: assert property (@(posedge clk) disable iff (rst)
    (!$past(run_q) && ($past(mode_i) != TRIG_MODE_RETRIG)) |-> !run_q);

  // R4: a single-pass end of count with no colliding edge drops the enable bit
  a_r4_sp_clears_enable: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !$past(cont_i) && !$past(start)) |-> !en_o);

  // R9: a colliding edge keeps the timer running
  a_r9_reload_wins: assert property (@(posedge clk) disable iff (rst)
    ($past(start) && !$past(en_clr_i)) |-> run_q);
endmodule

// File: tb/sim_retrig_timer.sv
module sim_retrig_timer;
  localparam int CLK_P = 10;
  localparam int W = 4;

  logic clk = 0, rst = 1, tick = 1, trig = 1, cont = 0, en_set = 0, en_clr = 0;
  logic [W-1:0] init = '0;
  logic [1:0] mode = 2'b11;
  logic en_o, irq;
  int vectors = 0, errs = 0;
  bit done = 0;

  retrig_timer #(.W(W)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .trig_i(trig), .init_i(init),
    .mode_i(mode), .cont_i(cont), .en_set_i(en_set), .en_clr_i(en_clr),
    .en_o(en_o), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic arm();
    en_set = 1; step(); en_set = 0;
  endtask

  task automatic settle_high();
    trig = 1;
    for (int i = 0; i < 4; i++) step();
  endtask

  initial begin
    #(CLK_P*20000);
    errs++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    int expn, fired, tc;
    step(); step(); rst = 0; step();
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 en", en_o, 0);

    // R2/R4 single-pass sweep over every start value
    for (int v = 0; v < 16; v++) begin
      init = W'(v); cont = 0; mode = 2'b11;
      expn = (v == 0) ? 16 : v;
      settle_high(); arm();
      check("R2 en after set", en_o, 1);
      trig = 0;
      for (int n = 1; n <= expn + 5; n++) begin
        step();
        check("R2 irq timing", irq, (n == expn + 3) ? 1 : 0);
      end
      check("R4 enable cleared", en_o, 0);
    end

    // R5 edges ignored after single-pass end
    settle_high(); trig = 0;
    for (int n = 0; n < 30; n++) begin step(); check("R5 irq", irq, 0); end
    check("R5 en", en_o, 0);

    // R6 disabled: edge without enable
    init = 3; settle_high(); trig = 0;
    for (int n = 0; n < 20; n++) begin step(); check("R6 disabled irq", irq, 0); end

    // R6 wrong mode
    mode = 2'b01; settle_high(); arm(); trig = 0;
    for (int n = 0; n < 20; n++) begin step(); check("R6 mode irq", irq, 0); end
    check("R6 en kept", en_o, 1);
    en_clr = 1; step(); en_clr = 0; mode = 2'b11;
    check("R7 clear", en_o, 0);

    // R7 continuous
    init = 5; cont = 1; settle_high(); arm(); trig = 0;
    for (int n = 1; n <= 30; n++) begin
      step();
      check("R7 periodic irq", irq, (n >= 8 && (n - 8) % 5 == 0) ? 1 : 0);
    end
    check("R7 en running", en_o, 1);
    en_clr = 1; step(); en_clr = 0;
    check("R7 en cleared", en_o, 0);
    for (int n = 0; n < 20; n++) begin step(); check("R7 stopped irq", irq, 0); end

    // R8 retrigger in single-pass
    init = 10; cont = 0; settle_high(); arm(); trig = 0;
    for (int n = 1; n <= 30; n++) begin
      step();
      check("R8 retrigger irq", irq, (n == 19) ? 1 : 0);
      if (n == 2) trig = 1;
      if (n == 6) trig = 0;
    end

    // R9 edge collides with end of count
    init = 4; cont = 0; settle_high(); arm(); trig = 0;
    for (int n = 1; n <= 16; n++) begin
      step();
      check("R9 collision irq", irq, (n == 7 || n == 11) ? 1 : 0);
      if (n >= 8 && n <= 10) check("R9 en held", en_o, 1);
      if (n == 2) trig = 1;
      if (n == 4) trig = 0;
    end
    check("R9 en after", en_o, 0);

    // R3 prescaled ticks, several periods
    for (int p = 2; p <= 4; p++) begin
      init = 4; cont = 0; settle_high(); arm(); trig = 0;
      tc = 0; fired = 0;
      for (int n = 1; n <= 30; n++) begin
        tick = (n % p == 0);
        step();
        expn = 0;
        if (n >= 4 && tick && !fired) begin
          tc++;
          if (tc == 4) begin expn = 1; fired = 1; end
        end
        check("R3 prescaled irq", irq, expn);
      end
      tick = 1;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule